// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block is a down-counting interval timer seen by software as six 16-bit registers on a small word-addressed bus. Software loads a period, picks one-shot or repeating operation, and fires a start command. While it runs, the counter loses one per clock. When the counter is zero at a clock edge, a sticky timeout flag is raised and the counter reloads from the period. In one-shot operation it then halts. In repeating operation it carries on. The timeout flag, gated by an enable bit, drives a level interrupt that stays high until software clears the flag.

A build-time parameter picks one of two period variants. In the first, the period is a register that software may rewrite; rewriting it halts the counter and loads the new value. In the second, the period is a constant; a write to either period address only reloads the counter with that constant and leaves the run state alone. A snapshot register can latch the live count on request so that software can read a stable timestamp in two halves while counting goes on.

Top module: `cdt_timer`

## Requirements
- R1: After reset, status, control and snapshot read 0, the interrupt is low, the counter is stopped, and the period reads the build-time initial value (all ones by default) at address 2 (low half) and address 3 (high half).
- R2: While running, the count falls by exactly one per clock. When the count is zero at an edge, the timeout flag is set and the count reloads from the period, so one interval lasts period+1 clocks.
- R3: At a timeout with the repeat bit (control bit 1) at 0, the counter stops and the run bit (status bit 1) reads 0.
- R4: At a timeout with the repeat bit at 1, the counter keeps running.
- R5: A control write (address 1) stores interrupt enable in bit 0 and repeat in bit 1. Bit 2 is a start command, and bit 3 is a stop command that also suppresses that cycle's step. When both are set, stop wins. Control reads return bits 1:0, with bits 2 and 3 reading 0.
- R6: Status (address 0) reads the timeout flag in bit 0. A write of any value to address 0 clears the flag, but a timeout in the same cycle keeps it set.
- R7: The interrupt output is high exactly while the timeout flag and the enable bit are both 1.
- R8: With a writable period, a write to address 2 or 3 replaces that half of the period, stops the counter, and loads the count with the new full period.
- R9: With a fixed period, period reads always return the constant. A write to address 2 or 3 reloads the count with the constant and leaves the run state unchanged.
- R10: A write of any value to address 4 or 5 latches the count held before that edge. Addresses 4 and 5 read its low and high halves. Counting is not disturbed, and the snapshot changes only on such a write.
- R11: Read data appears on the cycle after the read strobe and reflects register state as it stood before that edge. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Every register write takes effect at the edge that samples it, and read data is due one edge after the read strobe. The bench therefore drives at falling edges and samples `bus_rdata` and `irq` at the next falling edge. A reference model updated at each rising edge gives the expected interrupt level on every cycle and the expected word for every read, taken from model state before that edge's update. Timeouts fall period+1 edges after a start, so the directed cases wait well past that point, or read snapshots a known number of edges apart, before they compare.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_STAT = 3'd0,
      A_CTRL = 3'd1,
      A_PLO  = 3'd2,
      A_PHI  = 3'd3,
      A_SLO  = 3'd4,
      A_SHI  = 3'd5
   } cdt_addr_e;

   localparam int B_TO    = 0;
   localparam int B_RUN   = 1;
   localparam int B_IEN   = 0;
   localparam int B_REP   = 1;
   localparam int B_START = 2;
   localparam int B_STOP  = 3;

   typedef struct packed {
      logic clr_to;
      logic ctl_wr;
      logic start;
      logic stop;
      logic per_lo;
      logic per_hi;
      logic snap;
   } cdt_cmd_t;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
   import cdt_pkg::*;
(
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              start_bit,
   input  logic              stop_bit,
   output cdt_cmd_t          cmd
);
   always_comb begin
      cmd = '0;
      if (bus_wr) begin
         case (cdt_addr_e'(bus_addr))
            A_STAT: cmd.clr_to = 1'b1;
            A_CTRL: begin
               cmd.ctl_wr = 1'b1;
               cmd.start  = start_bit;
               cmd.stop   = stop_bit;
            end
            A_PLO:  cmd.per_lo = 1'b1;
            A_PHI:  cmd.per_hi = 1'b1;
            A_SLO,
            A_SHI:  cmd.snap   = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
   import cdt_pkg::*;
#(
   parameter int                  HALF_W          = 16,
   parameter bit                  WRITABLE_PERIOD = 1'b1,
   parameter logic [2*HALF_W-1:0] PERIOD_INIT     = '1,
   localparam int                 CNT_W           = 2*HALF_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              per_lo,
   input  logic              per_hi,
   input  logic [HALF_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              to_flag,
   input  logic              run,
   input  logic [CNT_W-1:0]  snap,
   output logic              ien,
   output logic              rep,
   output logic [CNT_W-1:0]  period,
   output logic              load,
   output logic              load_stop,
   output logic [CNT_W-1:0]  load_val,
   output logic [HALF_W-1:0] bus_rdata
);
   logic [HALF_W-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien <= 1'b0;
         rep <= 1'b0;
      end else if (ctl_wr) begin
         ien <= bus_wdata[B_IEN];
         rep <= bus_wdata[B_REP];
      end
   end

   assign load = per_lo | per_hi;

   generate
      if (WRITABLE_PERIOD) begin : g_wr_period
         logic [CNT_W-1:0] period_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               period_q <= PERIOD_INIT;
            else if (per_lo)
               period_q[HALF_W-1:0] <= bus_wdata;
            else if (per_hi)
               period_q[CNT_W-1:HALF_W] <= bus_wdata;
         end
         always_comb begin
            load_val = period_q;
            if (per_lo)
               load_val[HALF_W-1:0] = bus_wdata;
            else if (per_hi)
               load_val[CNT_W-1:HALF_W] = bus_wdata;
         end
         assign period    = period_q;
         assign load_stop = 1'b1;
      end else begin : g_fix_period
         logic unused_wdata;
         assign unused_wdata = ^bus_wdata[HALF_W-1:2];
         assign period    = PERIOD_INIT;
         assign load_val  = PERIOD_INIT;
         assign load_stop = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      case (cdt_addr_e'(bus_addr))
         A_STAT: begin
            rd_mux[B_TO]  = to_flag;
            rd_mux[B_RUN] = run;
         end
         A_CTRL: begin
            rd_mux[B_IEN] = ien;
            rd_mux[B_REP] = rep;
         end
         A_PLO:  rd_mux = period[HALF_W-1:0];
         A_PHI:  rd_mux = period[CNT_W-1:HALF_W];
         A_SLO:  rd_mux = snap[HALF_W-1:0];
         A_SHI:  rd_mux = snap[CNT_W-1:HALF_W];
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
   parameter int               CNT_W      = 32,
   parameter logic [CNT_W-1:0] INIT_COUNT = '1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             load,
   input  logic             load_stop,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   input  logic             rep,
   input  logic             clr_to,
   output logic [CNT_W-1:0] cnt,
   output logic             run,
   output logic             to_flag
);
   logic step;
   logic at_zero;
   logic tick;

   assign step    = run & ~stop & ~load;
   assign at_zero = (cnt == '0);
   assign tick    = step & at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= INIT_COUNT;
      else if (load)
         cnt <= load_val;
      else if (tick)
         cnt <= reload;
      else if (step)
         cnt <= cnt - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         run <= 1'b0;
      else if (load && load_stop)
         run <= 1'b0;
      else if (stop)
         run <= 1'b0;
      else if (start)
         run <= 1'b1;
      else if (tick && !rep)
         run <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         to_flag <= 1'b0;
      else if (tick)
         to_flag <= 1'b1;
      else if (clr_to)
         to_flag <= 1'b0;
   end
endmodule

// File: rtl/cdt_snap.sv
module cdt_snap #(
   parameter int CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] snap
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         snap <= '0;
      else if (take)
         snap <= cnt;
   end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int                  HALF_W          = 16,
   parameter bit                  WRITABLE_PERIOD = 1'b1,
   parameter logic [2*HALF_W-1:0] PERIOD_INIT     = '1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int CNT_W = 2*HALF_W;

   generate
      if (HALF_W < 4) begin : g_bad_width
         $error("cdt_timer: HALF_W must hold the four control bits");
      end
   endgenerate

   cdt_cmd_t         cmd;
   logic             ien;
   logic             rep;
   logic [CNT_W-1:0] period;
   logic             load;
   logic             load_stop;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             to_flag;
   logic [CNT_W-1:0] snap;

   cdt_decode u_decode (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .start_bit (bus_wdata[B_START]),
      .stop_bit  (bus_wdata[B_STOP]),
      .cmd       (cmd)
   );

   cdt_regs #(
      .HALF_W          (HALF_W),
      .WRITABLE_PERIOD (WRITABLE_PERIOD),
      .PERIOD_INIT     (PERIOD_INIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (cmd.ctl_wr),
      .per_lo    (cmd.per_lo),
      .per_hi    (cmd.per_hi),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .to_flag   (to_flag),
      .run       (run),
      .snap      (snap),
      .ien       (ien),
      .rep       (rep),
      .period    (period),
      .load      (load),
      .load_stop (load_stop),
      .load_val  (load_val),
      .bus_rdata (bus_rdata)
   );

   cdt_count #(
      .CNT_W      (CNT_W),
      .INIT_COUNT (PERIOD_INIT)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd.start),
      .stop      (cmd.stop),
      .load      (load),
      .load_stop (load_stop),
      .load_val  (load_val),
      .reload    (period),
      .rep       (rep),
      .clr_to    (cmd.clr_to),
      .cnt       (cnt),
      .run       (run),
      .to_flag   (to_flag)
   );

   cdt_snap #(
      .CNT_W (CNT_W)
   ) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (cmd.snap),
      .cnt   (cnt),
      .snap  (snap)
   );

   assign irq = to_flag & ien;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
   parameter int               CNT_W           = 32,
   parameter bit               WRITABLE_PERIOD = 1'b1,
   parameter logic [CNT_W-1:0] PERIOD_INIT     = '1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [2:0]       bus_addr,
   input logic             stop_bit,
   input logic [1:0]       rdata_lo,
   input logic             irq,
   input logic             run,
   input logic             to_flag,
   input logic             rep,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] snap
);
   logic snap_wr;
   logic per_wr;
   assign snap_wr = bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5);
   assign per_wr  = bus_wr && (bus_addr == 3'd2 || bus_addr == 3'd3);

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run && !bus_wr && cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1)); // R2
   AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
      run && !bus_wr && cnt == '0 && !rep |=> !run && to_flag); // R3
   AST_REPEAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      run && !bus_wr && cnt == '0 && rep |=> run && to_flag); // R4
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd1 && stop_bit |=> !run); // R5
   AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd0 && !(run && cnt == '0) |=> !to_flag); // R6
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !(bus_wr && bus_addr <= 3'd1) |=> irq); // R7
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_wr |=> $stable(snap)); // R10
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_wr |=> snap == $past(cnt)); // R10
   AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == 3'd0 |=> rdata_lo == {$past(run), $past(to_flag)}); // R11

   generate
      if (WRITABLE_PERIOD) begin : g_wr_chk
         AST_PER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            per_wr |=> !run); // R8
      end else begin : g_fix_chk
         AST_FIX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            per_wr && !(bus_addr == 3'd1) |=> cnt == PERIOD_INIT && run == $past(run)); // R9
      end
   endgenerate
endmodule

bind cdt_timer cdt_timer_chk #(
   .CNT_W           (CNT_W),
   .WRITABLE_PERIOD (WRITABLE_PERIOD),
   .PERIOD_INIT     (PERIOD_INIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .stop_bit (bus_wdata[3]),
   .rdata_lo (bus_rdata[1:0]),
   .irq      (irq),
   .run      (run),
   .to_flag  (to_flag),
   .rep      (rep),
   .cnt      (cnt),
   .snap     (snap)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
   localparam int          HW   = 16;
   localparam logic [31:0] FIXP = 32'd20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_a = 1'b0, rd_a = 1'b0, wr_f = 1'b0, rd_f = 1'b0;
   logic [2:0]    addr = '0;
   logic [HW-1:0] wdata = '0;
   logic [HW-1:0] rdata_a, rdata_f;
   logic          irq_a, irq_f;

   int total = 0;
   int bad   = 0;
   bit mon_on = 1'b0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cdt_timer u_cdt_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_rd(rd_a),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq(irq_a));

   cdt_timer #(.WRITABLE_PERIOD(1'b0), .PERIOD_INIT(FIXP)) u_cdt_timer_fix (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr_f), .bus_rd(rd_f),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_f), .irq(irq_f));

   // reference model of the writable instance, built from the requirements
   logic [31:0] m_cnt, m_per, m_snap;
   logic        m_run, m_to, m_ien, m_rep;
   logic [15:0] exp_rd;
   logic [2:0]  exp_addr;
   bit          exp_v;

   function automatic logic [15:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return {14'd0, m_run, m_to};
         3'd1: return {14'd0, m_rep, m_ien};
         3'd2: return m_per[15:0];
         3'd3: return m_per[31:16];
         3'd4: return m_snap[15:0];
         3'd5: return m_snap[31:16];
         default: return 16'd0;
      endcase
   endfunction

   task automatic model_step();
      bit clr, ctl, go, halt, pw, sw, tick, stp;
      logic [31:0] nper;
      clr  = wr_a && addr == 3'd0;
      ctl  = wr_a && addr == 3'd1;
      go   = ctl && wdata[2];
      halt = ctl && wdata[3];
      pw   = wr_a && (addr == 3'd2 || addr == 3'd3);
      sw   = wr_a && (addr == 3'd4 || addr == 3'd5);
      nper = m_per;
      if (wr_a && addr == 3'd2) nper[15:0]  = wdata;
      if (wr_a && addr == 3'd3) nper[31:16] = wdata;
      stp  = m_run && !halt && !pw;
      tick = stp && m_cnt == 32'd0;
      if (sw) m_snap = m_cnt;
      if (pw) m_cnt = nper;
      else if (tick) m_cnt = m_per;
      else if (stp) m_cnt = m_cnt - 32'd1;
      if (pw || halt) m_run = 1'b0;
      else if (go) m_run = 1'b1;
      else if (tick && !m_rep) m_run = 1'b0;
      if (tick) m_to = 1'b1;
      else if (clr) m_to = 1'b0;
      if (ctl) begin
         m_ien = wdata[0];
         m_rep = wdata[1];
      end
      m_per = nper;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '1; m_per = '1; m_snap = '0;
         m_run = 0; m_to = 0; m_ien = 0; m_rep = 0;
         exp_v = 0;
      end else begin
         exp_v = rd_a;
         if (rd_a) begin
            exp_rd   = model_read(addr);
            exp_addr = addr;
         end
         model_step();
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (mon_on) begin
         chk({31'd0, irq_a}, {31'd0, m_to & m_ien}, "R7 irq level");
         if (exp_v) begin
            case (exp_addr)
               3'd0: chk({16'd0, rdata_a}, {16'd0, exp_rd}, "R6 R11 status read");
               3'd1: chk({16'd0, rdata_a}, {16'd0, exp_rd}, "R5 R11 control read");
               3'd2, 3'd3: chk({16'd0, rdata_a}, {16'd0, exp_rd}, "R8 R11 period read");
               3'd4, 3'd5: chk({16'd0, rdata_a}, {16'd0, exp_rd}, "R10 R11 snapshot read");
               default: chk({16'd0, rdata_a}, {16'd0, exp_rd}, "R11 unused address read");
            endcase
         end
      end
   end

   task automatic wr(input bit fix, input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_a = !fix; wr_f = fix;
      @(posedge clk);
      #1 wr_a = 0; wr_f = 0;
   endtask

   task automatic rd(input bit fix, input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a; rd_a = !fix; rd_f = fix;
      @(posedge clk);
      #1 rd_a = 0; rd_f = 0;
      v = fix ? rdata_f : rdata_a;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [15:0] v, s1, s2;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      mon_on = 1'b1;

      // R1: reset state
      rd(0, 3'd0, v); chk(v, 0, "R1 status after reset");
      rd(0, 3'd1, v); chk(v, 0, "R1 control after reset");
      rd(0, 3'd2, v); chk(v, 16'hFFFF, "R1 period low after reset");
      rd(0, 3'd3, v); chk(v, 16'hFFFF, "R1 period high after reset");
      rd(0, 3'd4, v); chk(v, 0, "R1 snapshot after reset");
      chk(irq_a, 0, "R1 irq after reset");

      // R2: step of one per clock, snapshots two edges apart
      wr(0, 3'd3, 16'd0);
      wr(0, 3'd2, 16'd1000);
      wr(0, 3'd1, 16'h0004);
      wr(0, 3'd4, 16'h1234);
      rd(0, 3'd4, s1);
      wr(0, 3'd5, 16'h0000);
      rd(0, 3'd4, s2);
      chk(32'(s1 - s2), 32'd2, "R2 decrement per clock");
      chk(s1, 16'd1000, "R10 snapshot of count after start");

      // R3, R7, R6: one-shot with interrupt enabled
      wr(0, 3'd2, 16'd5);
      wr(0, 3'd1, 16'h0005);
      repeat (20) @(posedge clk);
      rd(0, 3'd0, v); chk(v, 16'h0001, "R3 one-shot stopped with timeout");
      chk(irq_a, 1, "R7 irq high after timeout");
      wr(0, 3'd0, 16'hABCD);
      rd(0, 3'd0, v); chk(v, 16'h0000, "R6 any write clears timeout");
      chk(irq_a, 0, "R7 irq low after clear");

      // R4: repeating mode keeps running
      wr(0, 3'd1, 16'h0006);
      repeat (30) @(posedge clk);
      rd(0, 3'd0, v); chk(v, 16'h0003, "R4 repeating still running");
      wr(0, 3'd1, 16'h0008);
      rd(0, 3'd0, v); chk(v[1], 0, "R5 stop halts");

      // R5: start and stop together, control readback
      wr(0, 3'd1, 16'h000F);
      rd(0, 3'd1, v); chk(v, 16'h0003, "R5 control readback");
      rd(0, 3'd0, v); chk(v[1], 0, "R5 stop wins over start");

      // R8: period write stops a running counter
      wr(0, 3'd1, 16'h0004);
      wr(0, 3'd3, 16'd1);
      rd(0, 3'd0, v); chk(v[1], 0, "R8 period write stops");
      rd(0, 3'd2, v); chk(v, 16'd5, "R8 period low kept");
      rd(0, 3'd3, v); chk(v, 16'd1, "R8 period high written");
      wr(0, 3'd3, 16'd0);

      // R9: fixed-period variant
      rd(1, 3'd2, v); chk(v, FIXP[15:0], "R9 fixed period read");
      wr(1, 3'd2, 16'd7);
      rd(1, 3'd2, v); chk(v, FIXP[15:0], "R9 fixed period ignores write");
      wr(1, 3'd1, 16'h0004);
      repeat (5) @(posedge clk);
      wr(1, 3'd3, 16'd3);
      wr(1, 3'd4, 16'd0);
      rd(1, 3'd4, v); chk(v, FIXP[15:0], "R9 period write reloads constant");
      rd(1, 3'd0, v); chk(v[1], 1, "R9 run kept after period write");

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom % 10;
         case (r)
            0, 1, 2: @(posedge clk);
            3, 4, 5: rd(0, 3'($urandom % 8), v);
            6: wr(0, 3'd0, 16'($urandom));
            7: wr(0, 3'd1, 16'($urandom % 16));
            8: if ($urandom % 2) wr(0, 3'd2, 16'($urandom % 24));
               else wr(0, 3'd3, 16'd0);
            default: wr(0, 3'($urandom % 2 + 4), 16'($urandom));
         endcase
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule